// File: doc/BRIEF.md
# Flag Offset Programming Unit

This unit keeps the two threshold offsets that a FIFO's flag logic uses to raise its almost-empty and almost-full indications, and drives both offsets to that logic on dedicated outputs. A master reset picks one of two default offset pairs from the level of the load pin. The same reset also fixes which programming method is used until the next master reset. When the load pin is low, both offsets become 127 and parallel programming is used. When it is high, both offsets become 1023 and serial programming is used.

After reset the offsets can be changed on the write clock. In parallel mode a word is taken from the write data bus. In serial mode one bit is taken from a serial input on each qualified edge. On the read clock the offsets can be read back over the read data bus in either mode. A partial reset rewinds the register-select state in both clock domains. It keeps the offsets and the programming method.

Top module: `flagOfsProg`

## Requirements
- R1: A write-clock edge with `masterRst` high and `ldPin` low sets both `aeOfs` and `afOfs` to 127 and `serialMode` to 0 (parallel). A read-clock edge with `masterRst` high clears `rdData` to 0.
- R2: A write-clock edge with `masterRst` high and `ldPin` high sets both `aeOfs` and `afOfs` to 1023 and `serialMode` to 1 (serial).
- R3: In parallel mode, each write-clock edge with `wrEn` and `ldPin` both high loads `wrData[OFS_W-1:0]` into one offset, and the upper data bits are ignored. The target alternates: the almost-empty offset first, then the almost-full offset, then back to the almost-empty offset.
- R4: In serial mode, each write-clock edge with `serialEn` and `ldPin` both high writes `serialIn` into the next offset bit, least-significant bit first. Bits 0 to OFS_W-1 of the almost-empty offset are filled first, then bits 0 to OFS_W-1 of the almost-full offset, and then the position wraps back to almost-empty bit 0.
- R5: The method not selected at master reset has no effect. In serial mode `wrEn` with `ldPin` leaves the offsets unchanged. In parallel mode `serialEn` with `ldPin` leaves them unchanged. With `ldPin` low, neither enable changes anything.
- R6: Each read-clock edge with `rdEn` and `ldPin` both high places one offset, zero-extended, on `rdData` from that edge on. The offset alternates: almost-empty first, then almost-full, with wrap-around. This works in both modes. Otherwise `rdData` holds its value.
- R7: A clock edge with `partialRst` high returns the parallel target, the serial bit position and the readback selection to the almost-empty offset (bit 0). Both offsets and `serialMode` are left unchanged.
- R8: When `partialRst` is high on the same edge as a load or readback strobe, the strobe is discarded. The offsets, the selection state and `rdData` are not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock; loading and defaults |
| rdClk | input | 1 | Read-side clock; readback |
| masterRst | input | 1 | Synchronous master reset, active high, sampled on both clocks |
| partialRst | input | 1 | Synchronous partial reset, active high, sampled on both clocks |
| ldPin | input | 1 | Load qualifier; its level at master reset selects defaults and method |
| wrEn | input | 1 | Parallel load enable |
| wrData | input | DATA_W | Write data bus carrying parallel offset words |
| serialEn | input | 1 | Serial load enable |
| serialIn | input | 1 | Serial offset bit |
| rdEn | input | 1 | Readback enable |
| rdData | output | DATA_W | Read data bus carrying read-back offsets |
| aeOfs | output | OFS_W | Current almost-empty offset |
| afOfs | output | OFS_W | Current almost-full offset |
| serialMode | output | 1 | 1 when serial programming is selected |

## Verification
A partial reset can land on the same write-clock edge as a parallel load, or on the same read-clock edge as a readback strobe. The bench provokes both cases by raising `partialRst` in the same cycle as `wrEn`/`rdEn` with `ldPin`. It judges the outcome at the ports: the offsets and `rdData` must stay unchanged, and the next strobe must target the almost-empty offset. Partial reset in the middle of a serial shift is judged the same way: the next bit shifted in must land in almost-empty bit 0.

// File: rtl/flagOfsPkg.sv
package flagOfsPkg;

  // widest serial bit index carried between control and datapath (offsets up to 64 bits)
  localparam int SER_IDX_W = 6;

  typedef struct packed {
    logic                 loadDefault;
    logic                 defaultHigh;
    logic                 parWrAe;
    logic                 parWrAf;
    logic                 serWr;
    logic                 serTargetAf;
    logic [SER_IDX_W-1:0] serBitIdx;
  } wrStrobe_t;

  typedef struct packed {
    logic clear;
    logic capture;
    logic selAf;
  } rdStrobe_t;

endpackage

// File: rtl/flagOfsCtrl.sv
module flagOfsCtrl
  import flagOfsPkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic      wrClk,
  input  logic      rdClk,
  input  logic      masterRst,
  input  logic      partialRst,
  input  logic      ldPin,
  input  logic      wrEn,
  input  logic      serialEn,
  input  logic      rdEn,
  output logic      serialMode,
  output wrStrobe_t wrStb,
  output rdStrobe_t rdStb
);

  localparam int TOTAL_BITS = 2 * OFS_W;
  localparam int BIT_W      = $clog2(TOTAL_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TOTAL_BITS - 1);
  localparam logic [BIT_W-1:0] HALF_BIT = BIT_W'(OFS_W);

  logic             parSelAf;
  logic [BIT_W-1:0] bitIdx;
  logic [BIT_W-1:0] lowIdx;
  logic             rdSelAf;
  logic             parGo;
  logic             serGo;
  logic             rdGo;

  // qualified requests in the write domain; any reset blocks them
  assign parGo = !masterRst && !partialRst && !serialMode && wrEn && ldPin;
  assign serGo = !masterRst && !partialRst &&  serialMode && serialEn && ldPin;
  assign rdGo  = !masterRst && !partialRst && rdEn && ldPin;

  // write-domain sequencing state
  always_ff @(posedge wrClk) begin
    if (masterRst) begin
      serialMode <= ldPin;
      parSelAf   <= 1'b0;
      bitIdx     <= '0;
    end else if (partialRst) begin
      parSelAf   <= 1'b0;
      bitIdx     <= '0;
    end else begin
      if (parGo) parSelAf <= ~parSelAf;
      if (serGo) bitIdx   <= (bitIdx == LAST_BIT) ? '0 : bitIdx + 1'b1;
    end
  end

  // read-domain selection toggle
  always_ff @(posedge rdClk) begin
    if (masterRst || partialRst) rdSelAf <= 1'b0;
    else if (rdEn && ldPin)      rdSelAf <= ~rdSelAf;
  end

  assign lowIdx = (bitIdx >= HALF_BIT) ? bitIdx - HALF_BIT : bitIdx;

  always_comb begin
    wrStb             = '0;
    wrStb.loadDefault = masterRst;
    wrStb.defaultHigh = ldPin;
    wrStb.parWrAe     = parGo && !parSelAf;
    wrStb.parWrAf     = parGo &&  parSelAf;
    wrStb.serWr       = serGo;
    wrStb.serTargetAf = bitIdx >= HALF_BIT;
    wrStb.serBitIdx   = SER_IDX_W'(lowIdx);
  end

  always_comb begin
    rdStb.clear   = masterRst;
    rdStb.capture = rdGo;
    rdStb.selAf   = rdSelAf;
  end

  // R3/R4: at most one register update strobe per write edge
  p_one_target_r3: assert property (@(posedge wrClk) disable iff (masterRst)
    $onehot0({wrStb.parWrAe, wrStb.parWrAf, wrStb.serWr}));

  // R7: partial reset rewinds both write-side selectors
  p_prst_rewind_r7: assert property (@(posedge wrClk) disable iff (masterRst)
    partialRst |=> (bitIdx == '0) && !parSelAf);

  // R7: partial reset rewinds the readback selector
  p_prst_rdsel_r7: assert property (@(posedge rdClk) disable iff (masterRst)
    partialRst |=> !rdSelAf);

  // R5: method never changes without master reset
  p_mode_fixed_r5: assert property (@(posedge wrClk) disable iff (masterRst)
    1'b1 |=> $stable(serialMode));

endmodule

// File: rtl/flagOfsDatapath.sv
module flagOfsDatapath
  import flagOfsPkg::*;
#(
  parameter int OFS_W       = 16,
  parameter int DATA_W      = 18,
  parameter int DEF_LOW     = 127,
  parameter int DEF_HIGH    = 1023
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              serialIn,
  input  logic [DATA_W-1:0] wrData,
  input  wrStrobe_t         wrStb,
  input  rdStrobe_t         rdStb,
  output logic [OFS_W-1:0]  aeOfs,
  output logic [OFS_W-1:0]  afOfs,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [OFS_W-1:0] DEF_LOW_V  = OFS_W'(DEF_LOW);
  localparam logic [OFS_W-1:0] DEF_HIGH_V = OFS_W'(DEF_HIGH);

  logic [OFS_W-1:0]  wordIn;
  logic [DATA_W-1:0] aeExt;
  logic [DATA_W-1:0] afExt;

  // width adaptation between the data bus and the offsets
  generate
    if (DATA_W > OFS_W) begin : g_wide_bus
      logic unusedHiBits;
      assign unusedHiBits = ^wrData[DATA_W-1:OFS_W];
      assign wordIn = wrData[OFS_W-1:0];
      assign aeExt  = {{(DATA_W-OFS_W){1'b0}}, aeOfs};
      assign afExt  = {{(DATA_W-OFS_W){1'b0}}, afOfs};
    end else begin : g_exact_bus
      assign wordIn = wrData;
      assign aeExt  = aeOfs;
      assign afExt  = afOfs;
    end
  endgenerate

  // offset registers, write domain
  always_ff @(posedge wrClk) begin
    if (wrStb.loadDefault) begin
      aeOfs <= wrStb.defaultHigh ? DEF_HIGH_V : DEF_LOW_V;
      afOfs <= wrStb.defaultHigh ? DEF_HIGH_V : DEF_LOW_V;
    end else begin
      if (wrStb.parWrAe) aeOfs <= wordIn;
      if (wrStb.parWrAf) afOfs <= wordIn;
      if (wrStb.serWr) begin
        for (int i = 0; i < OFS_W; i++) begin
          if (wrStb.serBitIdx == SER_IDX_W'(i)) begin
            if (wrStb.serTargetAf) afOfs[i] <= serialIn;
            else                   aeOfs[i] <= serialIn;
          end
        end
      end
    end
  end

  // readback register, read domain
  always_ff @(posedge rdClk) begin
    if (rdStb.clear)        rdData <= '0;
    else if (rdStb.capture) rdData <= rdStb.selAf ? afExt : aeExt;
  end

  // R6: bus holds unless a readback strobe is taken
  p_rd_hold_r6: assert property (@(posedge rdClk) disable iff (rdStb.clear)
    !rdStb.capture |=> $stable(rdData));

  // R3: a parallel almost-empty write leaves the almost-full offset alone
  p_par_ae_only_r3: assert property (@(posedge wrClk) disable iff (wrStb.loadDefault)
    wrStb.parWrAe |=> $stable(afOfs));

endmodule

// File: rtl/flagOfsProg.sv
module flagOfsProg
  import flagOfsPkg::*;
#(
  parameter int OFS_W    = 16,
  parameter int DATA_W   = 18,
  parameter int DEF_LOW  = 127,
  parameter int DEF_HIGH = 1023
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic              ldPin,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              serialEn,
  input  logic              serialIn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [OFS_W-1:0]  aeOfs,
  output logic [OFS_W-1:0]  afOfs,
  output logic              serialMode
);

  wrStrobe_t wrStb;
  rdStrobe_t rdStb;

  flagOfsCtrl #(.OFS_W(OFS_W)) u_ctrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .masterRst  (masterRst),
    .partialRst (partialRst),
    .ldPin      (ldPin),
    .wrEn       (wrEn),
    .serialEn   (serialEn),
    .rdEn       (rdEn),
    .serialMode (serialMode),
    .wrStb      (wrStb),
    .rdStb      (rdStb)
  );

  flagOfsDatapath #(
    .OFS_W    (OFS_W),
    .DATA_W   (DATA_W),
    .DEF_LOW  (DEF_LOW),
    .DEF_HIGH (DEF_HIGH)
  ) u_dp (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .serialIn (serialIn),
    .wrData   (wrData),
    .wrStb    (wrStb),
    .rdStb    (rdStb),
    .aeOfs    (aeOfs),
    .afOfs    (afOfs),
    .rdData   (rdData)
  );

  // R7/R8: partial reset never disturbs the offsets or the method
  p_prst_keeps_r8: assert property (@(posedge wrClk) disable iff (masterRst)
    partialRst |=> $stable(aeOfs) && $stable(afOfs) && $stable(serialMode));

  // R5: with no strobe of the selected method, offsets hold
  p_idle_hold_r5: assert property (@(posedge wrClk) disable iff (masterRst)
    !(ldPin && (serialMode ? serialEn : wrEn)) |=> $stable(aeOfs) && $stable(afOfs));

endmodule

// File: tb/tb_flagOfsProg.sv
module tb_flagOfsProg;

  localparam int OW = 10;
  localparam int DW = 12;

  logic          wrClk = 1'b0;
  logic          rdClk = 1'b0;
  logic          masterRst = 1'b0, partialRst = 1'b0, ldPin = 1'b0;
  logic          wrEn = 1'b0, serialEn = 1'b0, serialIn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [OW-1:0] aeOfs, afOfs;
  logic          serialMode;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;
  int expAe, expAf;

  flagOfsProg #(.OFS_W(OW), .DATA_W(DW)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .ldPin(ldPin), .wrEn(wrEn), .wrData(wrData), .serialEn(serialEn),
    .serialIn(serialIn), .rdEn(rdEn), .rdData(rdData), .aeOfs(aeOfs),
    .afOfs(afOfs), .serialMode(serialMode)
  );

  // 250 MHz on both clocks, read clock lagging by a quarter period
  always #2 wrClk = ~wrClk;
  initial begin
    #1;
    forever #2 rdClk = ~rdClk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mreset(input logic lvl);
    @(negedge wrClk);
    masterRst = 1'b1; ldPin = lvl;
    repeat (3) @(negedge wrClk);
    masterRst = 1'b0; ldPin = 1'b0;
  endtask

  task automatic wrWord(input int v);
    @(negedge wrClk);
    wrEn = 1'b1; ldPin = 1'b1; wrData = DW'(v);
    @(negedge wrClk);
    wrEn = 1'b0; ldPin = 1'b0;
  endtask

  task automatic shBit(input logic b);
    @(negedge wrClk);
    serialEn = 1'b1; ldPin = 1'b1; serialIn = b;
    @(negedge wrClk);
    serialEn = 1'b0; ldPin = 1'b0;
  endtask

  task automatic shWord(input int v);
    for (int k = 0; k < OW; k++) shBit(v[k]);
  endtask

  task automatic rdWord(output int v);
    @(negedge rdClk);
    rdEn = 1'b1; ldPin = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0; ldPin = 1'b0;
    v = int'(rdData);
  endtask

  // partial reset, optionally with a coincident write or read strobe
  task automatic preset(input bit withWr, input bit withRd, input int v);
    @(negedge wrClk);
    partialRst = 1'b1;
    if (withWr) begin wrEn = 1'b1; ldPin = 1'b1; wrData = DW'(v); end
    if (withRd) begin rdEn = 1'b1; ldPin = 1'b1; end
    @(negedge wrClk);
    partialRst = 1'b0; wrEn = 1'b0; rdEn = 1'b0; ldPin = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int r, a, b, held;

    // R1 defaults after low-level master reset
    mreset(1'b0);
    chk("R1 ae default", int'(aeOfs), 127);
    chk("R1 af default", int'(afOfs), 127);
    chk("R1 parallel mode", int'(serialMode), 0);
    chk("R1 rdData cleared", int'(rdData), 0);

    // R6 readback of defaults, with wrap to almost-empty
    rdWord(r); chk("R6 rd ae default", r, 127);
    rdWord(r); chk("R6 rd af default", r, 127);

    // R3 parallel sweep with alternating targets and R6 readback order
    expAe = 127; expAf = 127;
    for (int i = 0; i < 40; i++) begin
      a = (i * 97 + 5) % 1024;
      b = (i * 331 + 17) % 1024;
      wrWord(a | (((i % 4)) << OW)); expAe = a;
      chk("R3 par ae", int'(aeOfs), expAe);
      chk("R3 par af untouched", int'(afOfs), expAf);
      wrWord(b); expAf = b;
      chk("R3 par af", int'(afOfs), expAf);
      rdWord(r); chk("R6 rd ae", r, expAe);
      rdWord(r); chk("R6 rd af", r, expAf);
    end

    // R3 extremes, upper data bits ignored
    wrWord(12'hFFF); expAe = 1023;
    wrWord(12'hC00); expAf = 0;
    chk("R3 ae max", int'(aeOfs), 1023);
    chk("R3 af zero", int'(afOfs), 0);

    // R5 serial strobe ignored in parallel mode; enables without ldPin ignored
    for (int k = 0; k < 3; k++) shBit(1'b1);
    chk("R5 serial ignored ae", int'(aeOfs), expAe);
    chk("R5 serial ignored af", int'(afOfs), expAf);
    @(negedge wrClk); wrEn = 1'b1; wrData = 12'h055;
    @(negedge wrClk); wrEn = 1'b0;
    chk("R5 no ld ae", int'(aeOfs), expAe);
    chk("R5 no ld af", int'(afOfs), expAf);

    // R7 partial reset mid-pair rewinds the target to almost-empty
    wrWord(300); expAe = 300;
    preset(0, 0, 0);
    chk("R7 prst keeps ae", int'(aeOfs), 300);
    chk("R7 prst keeps mode", int'(serialMode), 0);
    wrWord(301); expAe = 301;
    chk("R7 next goes to ae", int'(aeOfs), 301);
    chk("R7 af kept", int'(afOfs), expAf);
    wrWord(302); expAf = 302;
    rdWord(r); chk("R7 rd ae before", r, 301);
    preset(0, 0, 0);
    rdWord(r); chk("R7 rd rewound to ae", r, 301);

    // R8 coincident parallel write discarded
    preset(1, 0, 555);
    chk("R8 wr dropped ae", int'(aeOfs), expAe);
    chk("R8 wr dropped af", int'(afOfs), expAf);
    wrWord(556); expAe = 556;
    chk("R8 target still ae", int'(aeOfs), 556);
    wrWord(557); expAf = 557;

    // R8 coincident readback discarded
    rdWord(r); held = r;
    preset(0, 1, 0);
    chk("R8 rd dropped", int'(rdData), held);
    rdWord(r); chk("R8 rd sel ae", r, expAe);

    // R2 defaults after high-level master reset
    mreset(1'b1);
    chk("R2 ae default", int'(aeOfs), 1023);
    chk("R2 af default", int'(afOfs), 1023);
    chk("R2 serial mode", int'(serialMode), 1);
    expAe = 1023; expAf = 1023;

    // R5 parallel strobe ignored in serial mode
    wrWord(5);
    chk("R5 par ignored ae", int'(aeOfs), 1023);
    chk("R5 par ignored af", int'(afOfs), 1023);

    // R4 serial sweep, counter wraps across words
    for (int i = 0; i < 8; i++) begin
      a = (i * 233 + 9) % 1024;
      b = (i * 611 + 400) % 1024;
      shWord(a); expAe = a;
      chk("R4 ser ae", int'(aeOfs), expAe);
      chk("R4 ser af untouched", int'(afOfs), expAf);
      shWord(b); expAf = b;
      chk("R4 ser af", int'(afOfs), expAf);
      rdWord(r); chk("R6 rd ae serial", r, expAe);
      rdWord(r); chk("R6 rd af serial", r, expAf);
    end

    // R7 partial reset mid-shift rewinds to almost-empty bit 0
    for (int k = 0; k < 4; k++) shBit(1'b1);
    preset(0, 0, 0);
    chk("R7 prst keeps serial mode", int'(serialMode), 1);
    shWord(10'h2A5); expAe = 10'h2A5;
    chk("R7 ser restart ae", int'(aeOfs), expAe);
    chk("R7 ser af kept", int'(afOfs), expAf);

    // R1 master reset restores defaults after programming
    mreset(1'b0);
    chk("R1 ae restored", int'(aeOfs), 127);
    chk("R1 af restored", int'(afOfs), 127);
    chk("R1 mode restored", int'(serialMode), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule